// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block is one DMA channel. It copies a block of 8-, 16- or 32-bit items from one memory-mapped location to another over a simple request/done memory port. Software fills in a transfer setup on the configuration inputs: item width, item count minus one, an increment enable for each side, a descriptor-valid bit, a chain (reload) bit and a choice between two completion flags. It also places a small descriptor in memory. The descriptor table starts on a 512-byte boundary, and the table base input carries address bits 31:9. The slot for this channel sits at base + 16 × channel index.

Each 16-byte slot holds four words. Offset 0 is unused by the engine, offset 4 is the source end address, offset 8 is the destination end address and offset 12 is the address of the next descriptor. Because the slot stores end addresses, the engine subtracts count × item size to recover each start address. It then moves the items one beat at a time: a read, then a write. Busy is high while it runs. When the descriptor is exhausted, the chosen completion flag is set, and software clears it by pulsing the matching clear input. A set pulse and a clear pulse control the enable. An abort input stops the channel at once. A bus error stops the channel and latches an error flag.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, `enabled`, `busy`, `flag_a`, `flag_b`, `err_flag` and `m_req` are all 0.
- R2: A pulse on `en_set` sets `enabled` at the next edge, and a pulse on `en_clr` clears it. When both pulses arrive together, clear wins.
- R3: A `sw_trig` pulse starts the channel only when `enabled` is 1, `cfg_valid` is 1 and the channel is idle. Busy is then 1 from the next edge. Any other trigger leaves busy at 0 and writes nothing to memory.
- R4: A run first reads, as 32-bit accesses, the word at slot+4 (source end) and then the word at slot+8 (destination end), where slot = {tbl_base, 9'b0} + 16 × CH_IDX. It reads the link word at slot+12 only when `cfg_reload` is 1.
- R5: A run moves `cfg_count`+1 items. With an increment enabled, the first address is end − `cfg_count` × size and each later beat adds size. With the increment disabled, every beat uses the stored end address.
- R6: `cfg_width` codes 0, 1 and 2 select 1, 2 and 4 bytes, and code 3 acts as 4 bytes. `m_size` carries the same code on data beats and 2 on descriptor reads. Data is right-aligned on `m_rdata` and `m_wdata`, and the bits above the item width are written as zero.
- R7: Every beat is a read at the source followed by a write at the destination, with only one access outstanding. While `m_req` is 1 and `m_done` is 0, `m_addr` and `m_we` stay unchanged unless `abort` is pulsed.
- R8: When the last write of a descriptor completes, `flag_a` is set if `cfg_flag_b` is 0, and `flag_b` is set otherwise. Busy drops in that same edge when the run ends. A clear pulse on `flag_a_clr` or `flag_b_clr` clears its flag, and a set in the same cycle wins over a clear.
- R9: With `cfg_reload` 1 and a non-zero link word, the engine loads the descriptor at the link address when the current one is exhausted. It runs that descriptor with the same setup, and a zero link ends the chain.
- R10: An `m_err` on any completed access sets `err_flag` and stops the channel, and no completion flag is set for that run. `err_clr` clears `err_flag`.
- R11: An `abort` pulse makes `busy` and `m_req` 0 at the next edge without setting a completion flag. It leaves `enabled` unchanged.
- R12: When `enabled` is cleared during a run, the engine finishes the access in flight and then goes idle without a completion flag, unless that access was the final write of the last descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | AW-9 | Descriptor table address bits AW-1:9 |
| en_set | input | 1 | Pulse: enable the channel |
| en_clr | input | 1 | Pulse: disable the channel |
| sw_trig | input | 1 | Pulse: start a run |
| abort | input | 1 | Pulse: stop the channel immediately |
| cfg_valid | input | 1 | Setup and descriptor are valid |
| cfg_reload | input | 1 | Follow the link word after each descriptor |
| cfg_flag_b | input | 1 | 0: completion sets flag A, 1: flag B |
| cfg_width | input | 2 | Item size code (0:8, 1:16, 2/3:32 bits) |
| cfg_src_inc | input | 1 | Step the source address each beat |
| cfg_dst_inc | input | 1 | Step the destination address each beat |
| cfg_count | input | CNT_W | Items to move minus one |
| flag_a_clr | input | 1 | Pulse: clear flag A |
| flag_b_clr | input | 1 | Pulse: clear flag B |
| err_clr | input | 1 | Pulse: clear the error flag |
| enabled | output | 1 | Channel enable state |
| busy | output | 1 | Run in progress |
| flag_a | output | 1 | Completion flag A |
| flag_b | output | 1 | Completion flag B |
| err_flag | output | 1 | Bus error seen |
| m_req | output | 1 | Memory access request |
| m_we | output | 1 | Access is a write |
| m_size | output | 2 | Access size code |
| m_addr | output | AW | Access byte address |
| m_wdata | output | 32 | Write data, right-aligned |
| m_rdata | input | 32 | Read data, right-aligned |
| m_done | input | 1 | Current access completes this cycle |
| m_err | input | 1 | Current access failed (valid with m_done) |

## Verification
The hardest case to reach is a stop that lands in the middle of a run: a disable or an abort that arrives while a descriptor fetch or a beat is still pending, and an error on one particular later beat. The bench's memory model adds a programmable latency to every access, which stretches each access over several cycles so that an `en_clr` or `abort` pulse, timed by cycle count after the trigger, lands inside the run. It can also flag one chosen address as failing. The partially written destination then shows exactly how many beats finished.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter int AW     = 32,
  parameter int CNT_W  = 10,
  parameter int CH_IDX = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-10:0]   tbl_base,
  input  logic             en_set,
  input  logic             en_clr,
  input  logic             sw_trig,
  input  logic             abort,
  input  logic             cfg_valid,
  input  logic             cfg_reload,
  input  logic             cfg_flag_b,
  input  logic [1:0]       cfg_width,
  input  logic             cfg_src_inc,
  input  logic             cfg_dst_inc,
  input  logic [CNT_W-1:0] cfg_count,
  input  logic             flag_a_clr,
  input  logic             flag_b_clr,
  input  logic             err_clr,
  output logic             enabled,
  output logic             busy,
  output logic             flag_a,
  output logic             flag_b,
  output logic             err_flag,
  output logic             m_req,
  output logic             m_we,
  output logic [1:0]       m_size,
  output logic [AW-1:0]    m_addr,
  output logic [31:0]      m_wdata,
  input  logic [31:0]      m_rdata,
  input  logic             m_done,
  input  logic             m_err
);

  localparam logic [AW-1:0] SLOT_OFS = AW'(CH_IDX) << 4;

  typedef enum logic [2:0] {S_IDLE, S_SRC, S_DST, S_LNK, S_RD, S_WR} st_t;

  st_t             st;
  logic [AW-1:0]   desc_ptr, src_a, dst_a, link_q;
  logic [CNT_W-1:0] rem, c_cnt;
  logic [1:0]      c_w;
  logic            c_sinc, c_dinc, c_reload, c_selb;
  logic [31:0]     data_q;

  logic [1:0]    sh;
  logic [AW-1:0] step, span, slot;
  logic [31:0]   mask;
  logic          start, acc_ok, last_wr, chain, exhaust;

  assign sh    = (c_w == 2'd3) ? 2'd2 : c_w;
  assign step  = AW'(1) << sh;
  assign span  = AW'(c_cnt) << sh;
  assign mask  = (sh == 2'd0) ? 32'h0000_00FF :
                 (sh == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
  assign slot  = {tbl_base, 9'b0} + SLOT_OFS;

  assign busy    = (st != S_IDLE);
  assign m_req   = busy;
  assign m_we    = (st == S_WR);
  assign m_size  = (st == S_RD || st == S_WR) ? sh : 2'd2;
  assign m_wdata = data_q;

  always_comb begin
    case (st)
      S_SRC:   m_addr = desc_ptr + AW'(4);
      S_DST:   m_addr = desc_ptr + AW'(8);
      S_LNK:   m_addr = desc_ptr + AW'(12);
      S_RD:    m_addr = src_a;
      S_WR:    m_addr = dst_a;
      default: m_addr = '0;
    endcase
  end

  assign start   = sw_trig && enabled && cfg_valid && !busy && !abort;
  assign acc_ok  = m_req && m_done && !m_err && !abort;
  assign last_wr = acc_ok && (st == S_WR) && (rem == '0);
  assign chain   = last_wr && c_reload && (link_q != '0) && enabled;
  assign exhaust = last_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enabled <= 1'b0;
    else if (en_clr) enabled <= 1'b0;
    else if (en_set) enabled <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_a   <= 1'b0;
      flag_b   <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      flag_a   <= (exhaust && !c_selb) || (flag_a && !flag_a_clr);
      flag_b   <= (exhaust && c_selb) || (flag_b && !flag_b_clr);
      err_flag <= (m_req && m_done && m_err) || (err_flag && !err_clr);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      desc_ptr <= '0;
      src_a    <= '0;
      dst_a    <= '0;
      link_q   <= '0;
      rem      <= '0;
      c_cnt    <= '0;
      c_w      <= '0;
      c_sinc   <= 1'b0;
      c_dinc   <= 1'b0;
      c_reload <= 1'b0;
      c_selb   <= 1'b0;
      data_q   <= '0;
    end else if (abort || (m_req && m_done && m_err)) begin
      st <= S_IDLE;
    end else if (start) begin
      st       <= S_SRC;
      desc_ptr <= slot;
      link_q   <= '0;
      rem      <= cfg_count;
      c_cnt    <= cfg_count;
      c_w      <= cfg_width;
      c_sinc   <= cfg_src_inc;
      c_dinc   <= cfg_dst_inc;
      c_reload <= cfg_reload;
      c_selb   <= cfg_flag_b;
    end else if (acc_ok) begin
      case (st)
        S_SRC: begin
          src_a <= c_sinc ? m_rdata[AW-1:0] - span : m_rdata[AW-1:0];
          st    <= enabled ? S_DST : S_IDLE;
        end
        S_DST: begin
          dst_a <= c_dinc ? m_rdata[AW-1:0] - span : m_rdata[AW-1:0];
          if (!enabled)     st <= S_IDLE;
          else if (c_reload) st <= S_LNK;
          else              st <= S_RD;
        end
        S_LNK: begin
          link_q <= m_rdata[AW-1:0];
          st     <= enabled ? S_RD : S_IDLE;
        end
        S_RD: begin
          data_q <= m_rdata & mask;
          st     <= enabled ? S_WR : S_IDLE;
        end
        S_WR: begin
          if (rem == '0) begin
            if (chain) begin
              desc_ptr <= link_q;
              link_q   <= '0;
              rem      <= c_cnt;
              st       <= S_SRC;
            end else begin
              st <= S_IDLE;
            end
          end else begin
            rem <= rem - 1'b1;
            if (c_sinc) src_a <= src_a + step;
            if (c_dinc) dst_a <= dst_a + step;
            st <= enabled ? S_RD : S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R3
  trig_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_trig && enabled && cfg_valid && !busy && !abort) |=> busy);

  // R7
  hold_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_done && !abort) |=> ($stable(m_addr) && $stable(m_we) && m_req));

  // R8
  flag_from_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_a) || $rose(flag_b)) |-> $past(busy));

  // R10
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && m_done && m_err) |=> (err_flag && !busy));

  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!busy && !m_req));

endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb;
  localparam int CLK_P = 10;
  localparam int AW = 32;
  localparam int CNT_W = 10;
  localparam int CH = 3;
  localparam int SLOT = 32'h400 + CH * 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-10:0] tbl_base = 23'd2;
  logic en_set = 0, en_clr = 0, sw_trig = 0, abort = 0;
  logic cfg_valid = 0, cfg_reload = 0, cfg_flag_b = 0;
  logic [1:0] cfg_width = 0;
  logic cfg_src_inc = 0, cfg_dst_inc = 0;
  logic [CNT_W-1:0] cfg_count = 0;
  logic flag_a_clr = 0, flag_b_clr = 0, err_clr = 0;
  logic enabled, busy, flag_a, flag_b, err_flag;
  logic m_req, m_we, m_done, m_err;
  logic [1:0] m_size;
  logic [AW-1:0] m_addr;
  logic [31:0] m_wdata, m_rdata;

  always #(CLK_P/2) clk = ~clk;

  dma_chan_engine #(.AW(AW), .CNT_W(CNT_W), .CH_IDX(CH)) u_dut (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base),
    .en_set(en_set), .en_clr(en_clr), .sw_trig(sw_trig), .abort(abort),
    .cfg_valid(cfg_valid), .cfg_reload(cfg_reload), .cfg_flag_b(cfg_flag_b),
    .cfg_width(cfg_width), .cfg_src_inc(cfg_src_inc), .cfg_dst_inc(cfg_dst_inc),
    .cfg_count(cfg_count), .flag_a_clr(flag_a_clr), .flag_b_clr(flag_b_clr),
    .err_clr(err_clr), .enabled(enabled), .busy(busy), .flag_a(flag_a),
    .flag_b(flag_b), .err_flag(err_flag), .m_req(m_req), .m_we(m_we),
    .m_size(m_size), .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata),
    .m_done(m_done), .m_err(m_err));

  // memory model
  logic [7:0] mem [0:4099];
  logic [7:0] exp_mem [0:4099];
  logic [3:0] lat = 0, wcnt = 0;
  logic err_on = 0;
  logic [31:0] err_addr = 0;
  logic link_seen = 0;
  logic [12:0] ai;

  assign ai = {1'b0, m_addr[11:0]};
  assign m_done = m_req && (wcnt == lat);
  assign m_err = m_done && err_on && (m_addr == err_addr);
  always_comb begin
    m_rdata = {mem[ai+3], mem[ai+2], mem[ai+1], mem[ai]};
    if (m_size == 2'd0) m_rdata[31:8] = '0;
    else if (m_size == 2'd1) m_rdata[31:16] = '0;
  end

  always @(posedge clk) begin
    if (!m_req || m_done) wcnt <= 0; else wcnt <= wcnt + 1;
    if (m_done && !m_err && m_addr == SLOT + 12) link_seen <= 1'b1;
    if (m_done && m_we && !m_err) begin
      mem[ai] <= m_wdata[7:0];
      if (m_size != 2'd0) mem[ai+1] <= m_wdata[15:8];
      if (m_size[1]) begin
        mem[ai+2] <= m_wdata[23:16];
        mem[ai+3] <= m_wdata[31:24];
      end
    end
  end

  int checks = 0, errors = 0, cyc = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic put_word(input int a, input logic [31:0] v);
    for (int k = 0; k < 4; k++) mem[a+k] = v[8*k +: 8];
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic clear_all();
    for (int i = 0; i < 4100; i++) mem[i] = 8'h00;
  endtask

  task automatic snap();
    for (int i = 0; i < 4100; i++) exp_mem[i] = mem[i];
  endtask

  task automatic model_copy(input int w, input int si, input int di, input int cnt,
                            input int s0, input int d0, input int nbeats);
    int n;
    n = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    for (int b = 0; b < nbeats && b <= cnt; b++)
      for (int k = 0; k < n; k++)
        exp_mem[d0 + (di ? b*n : 0) + k] = exp_mem[s0 + (si ? b*n : 0) + k];
  endtask

  function automatic int mem_diff();
    int d = 0;
    for (int i = 0; i < 4100; i++) if (mem[i] !== exp_mem[i]) d++;
    return d;
  endfunction

  task automatic setup(input int w, input int si, input int di, input int cnt,
                       input int s0, input int d0, input bit selb);
    int n;
    n = (w == 0) ? 1 : (w == 1) ? 2 : 4;
    put_word(SLOT + 4, s0 + (si ? cnt*n : 0));
    put_word(SLOT + 8, d0 + (di ? cnt*n : 0));
    put_word(SLOT + 12, 0);
    cfg_width = w[1:0]; cfg_src_inc = si[0]; cfg_dst_inc = di[0];
    cfg_count = cnt[CNT_W-1:0]; cfg_flag_b = selb; cfg_valid = 1'b1;
  endtask

  typedef struct packed {
    logic [1:0] w; logic si; logic di; logic [9:0] cnt; logic selb;
    logic [11:0] s0; logic [11:0] d0;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd2, 1'b1, 1'b1, 10'd3,  1'b0, 12'h100, 12'h800},
    '{2'd0, 1'b1, 1'b1, 10'd0,  1'b1, 12'h121, 12'h841},
    '{2'd1, 1'b1, 1'b0, 10'd4,  1'b0, 12'h140, 12'h860},
    '{2'd2, 1'b0, 1'b1, 10'd2,  1'b1, 12'h160, 12'h880},
    '{2'd0, 1'b1, 1'b1, 10'd9,  1'b0, 12'h183, 12'h8A1},
    '{2'd3, 1'b1, 1'b1, 10'd1,  1'b1, 12'h1A0, 12'h8C0}
  };

  initial begin
    int d;
    clear_all();
    for (int i = 0; i < 256; i++) mem[32'h100 + i] = 8'((i * 7) ^ 8'h5A);
    for (int i = 0; i < 256; i++) mem[32'h200 + i] = 8'((i * 13) ^ 8'hC3);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !enabled && !flag_a && !flag_b && !err_flag && !m_req, "R1",
        {busy, enabled, flag_a, flag_b, err_flag, m_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 trigger ignored while disabled
    setup(2, 1, 1, 3, 32'h100, 32'h800, 0);
    snap();
    pulse(sw_trig);
    chk(!busy, "R3 disabled trig", busy, 0);
    repeat (10) @(negedge clk);
    d = mem_diff();
    chk(d == 0, "R3 no write when disabled", d, 0);

    // R2 enable set / clear, clear wins
    pulse(en_set);
    chk(enabled, "R2 set", enabled, 1);
    @(negedge clk); en_set = 1; en_clr = 1;
    @(negedge clk); en_set = 0; en_clr = 0;
    chk(!enabled, "R2 clear wins", enabled, 0);
    pulse(en_set);

    // R3 trigger ignored when descriptor not valid
    cfg_valid = 1'b0;
    pulse(sw_trig);
    chk(!busy, "R3 invalid trig", busy, 0);
    cfg_valid = 1'b1;

    // R4 first fetch address, R3 busy after trigger
    lat = 1;
    @(negedge clk); sw_trig = 1;
    @(negedge clk); sw_trig = 0;
    chk(busy && m_addr == SLOT + 4 && m_size == 2'd2 && !m_we, "R4 first fetch", m_addr, SLOT + 4);
    wait_idle();
    flag_a_clr = 1; @(negedge clk); flag_a_clr = 0;

    // vector table: R5 R6 R7 R8
    foreach (VECS[v]) begin
      vec_t t;
      t = VECS[v];
      lat = 4'(v % 3);
      for (int i = 32'h800; i < 32'h900; i++) mem[i] = 8'h00;
      setup(int'(t.w), int'(t.si), int'(t.di), int'(t.cnt), int'(t.s0), int'(t.d0), t.selb);
      snap();
      model_copy(int'(t.w), int'(t.si), int'(t.di), int'(t.cnt), int'(t.s0), int'(t.d0), 1024);
      link_seen = 0;
      pulse(sw_trig);
      chk(busy, "R8 busy during run", busy, 1);
      wait_idle();
      d = mem_diff();
      chk(d == 0, "R5 R6 R7 copy result", d, 0);
      chk(flag_a == !t.selb && flag_b == t.selb, "R8 flag select", {flag_a, flag_b}, {!t.selb, t.selb});
      chk(!link_seen, "R4 no link fetch", link_seen, 0);
      @(negedge clk); flag_a_clr = 1; flag_b_clr = 1;
      @(negedge clk); flag_a_clr = 0; flag_b_clr = 0;
      chk(!flag_a && !flag_b, "R8 flag clear", {flag_a, flag_b}, 0);
    end

    // R9 reload chain
    lat = 1;
    for (int i = 32'h800; i < 32'hB00; i++) mem[i] = 8'h00;
    setup(2, 1, 1, 3, 32'h100, 32'h900, 0);
    put_word(SLOT + 12, 32'h600);
    put_word(32'h604, 32'h200 + 12);
    put_word(32'h608, 32'hA00 + 12);
    put_word(32'h60C, 0);
    cfg_reload = 1;
    snap();
    model_copy(2, 1, 1, 3, 32'h100, 32'h900, 1024);
    model_copy(2, 1, 1, 3, 32'h200, 32'hA00, 1024);
    link_seen = 0;
    pulse(sw_trig);
    wait_idle();
    d = mem_diff();
    chk(d == 0, "R9 chained copy", d, 0);
    chk(link_seen, "R4 link fetched with reload", link_seen, 1);
    chk(flag_a, "R9 flag after chain", flag_a, 1);
    cfg_reload = 0;
    pulse(flag_a_clr);

    // R10 bus error on second read
    lat = 0;
    for (int i = 32'h800; i < 32'h900; i++) mem[i] = 8'h00;
    setup(2, 1, 1, 3, 32'h100, 32'h800, 0);
    snap();
    model_copy(2, 1, 1, 3, 32'h100, 32'h800, 1);
    err_on = 1; err_addr = 32'h104;
    pulse(sw_trig);
    wait_idle();
    err_on = 0;
    d = mem_diff();
    chk(d == 0, "R10 partial copy", d, 0);
    chk(err_flag && !flag_a && !busy, "R10 error stop", {err_flag, flag_a, busy}, 3'b100);
    pulse(err_clr);
    chk(!err_flag, "R10 error clear", err_flag, 0);

    // R11 abort mid-run
    lat = 5;
    setup(0, 1, 1, 20, 32'h100, 32'h800, 0);
    pulse(sw_trig);
    repeat (3) @(negedge clk);
    @(negedge clk); abort = 1;
    @(negedge clk); abort = 0;
    chk(!busy && !m_req, "R11 abort idle", {busy, m_req}, 0);
    chk(!flag_a && enabled, "R11 no flag, still enabled", {flag_a, enabled}, 2'b01);

    // R12 disable mid-run
    lat = 2;
    for (int i = 32'h800; i < 32'h900; i++) mem[i] = 8'h00;
    setup(0, 1, 1, 20, 32'h100, 32'h800, 0);
    pulse(sw_trig);
    repeat (12) @(negedge clk);
    pulse(en_clr);
    wait_idle();
    chk(!busy && !enabled && !flag_a, "R12 stop on disable", {busy, enabled, flag_a}, 0);
    chk(mem[32'h800] == mem[32'h100] && mem[32'h814] == 8'h00, "R12 partial",
        {mem[32'h800], mem[32'h814]}, {mem[32'h100], 8'h00});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule